// File: doc/BRIEF.md
# Two-Wire Fourteen-Channel Code Bank Target

This block is a target on a two-wire serial bus. It holds fourteen 8-bit output codes, one per reference channel, and presents all of them in parallel. Each channel has its own one-cycle update strobe, which fires when that channel is written. The bus lines are oversampled by the system clock. The block finds start and stop conditions, shifts in bytes most significant bit first and acknowledges by pulling SDA low through an open-drain enable. It can also transmit the stored codes back to the bus controller.

A strap input selects between two ways of programming the bank. With the strap high, the block runs in streaming mode. The first byte of a frame is the control byte and the second is an index byte, which is acknowledged and not used. Every later byte fills the next channel, starting at channel 1. With the strap low, the block runs in register mode. The second byte is a channel pointer and the third byte writes only the channel that pointer names. A system would program the whole bank with one streaming frame at start-up, then trim single channels in register mode.

Top module: `i2c_chan_bank`

## Requirements
- R1: After synchronous reset, every channel code is 8'h80, no update strobe is high and SDA is released (`sda_oe` = 0).
- R2: A start is SDA falling while SCL is high; a stop is SDA rising while SCL is high. After a stop, SDA is released, and clock pulses sent before the next start get no acknowledge and change no channel.
- R3: The first byte after a start is the control byte: bits 7..1 are the 7-bit target address (default 7'h2C) and bit 0 is R/W (1 = read). A matching address is acknowledged by holding SDA low through the ninth clock. A mismatch is not acknowledged, and the rest of the frame is ignored.
- R4: In streaming mode (`stream_mode` = 1), the second byte of a write frame is acknowledged and discarded. The third byte loads channel 1 (code bits [7:0]), the fourth byte loads channel 2, and so on in order, up to channel 14 (bits [111:104]).
- R5: In streaming mode, bytes after the one for channel 14 are acknowledged and discarded. A repeated start begins the next frame again at channel 1.
- R6: In register mode (`stream_mode` = 0), a second byte from 0 to 13 is acknowledged as a channel pointer (0 = channel 1). The third byte writes only that channel. Later bytes are acknowledged and discarded.
- R7: In register mode, a pointer byte of 14 or more is not acknowledged. The rest of the frame is then ignored and no channel changes.
- R8: Each channel write raises only that channel's strobe, for exactly one clock. A channel code changes only in the cycle its strobe is high.
- R9: After a read control byte is acknowledged, the block sends codes most significant bit first. It starts at channel 1 in streaming mode, or at the last accepted pointer in register mode. It moves to the next channel after each byte, wraps from channel 14 to channel 1, and releases SDA during every acknowledge clock.
- R10: When the controller does not acknowledge a read byte, the block releases SDA and drives nothing until the next start or stop.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level, as seen on the wire |
| stream_mode | input | 1 | Strap: 1 = streaming mode, 0 = register mode |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| chan_codes | output | 112 | Channel codes; channel n occupies bits [8n-1:8n-8] |
| chan_upd | output | 14 | Per-channel one-cycle update strobe; bit n-1 is channel n |

## Verification
The hardest states to reach from the ports are the ones behind a refusal. These include a bad address, a pointer of 14 or more, and a controller NACK during a read. In each case the block must stay silent for the rest of the frame. The stimulus keeps clocking bytes after each refusal and checks that none is acknowledged and that no code moves. It also clocks bits after a stop with no start, to show that bus activity outside a frame is ignored. For the read wrap, a register-mode frame sets the pointer to 12 and a repeated start follows directly. This shows the pointer carries over into the read, and that the read wraps past channel 14. Random frames on top of this mix the two modes, a foreign address, pointers outside the range and frame lengths that overrun the bank.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;

  // bit-level engine state
  typedef enum logic [1:0] {
    L_IDLE,
    L_RX,
    L_TX,
    L_IGN
  } link_st_t;

  // frame-level position
  typedef enum logic [2:0] {
    P_OFF,
    P_CTRL,
    P_INDEX,
    P_DATA,
    P_DROP,
    P_READ
  } phase_t;
endpackage

// File: rtl/i2cb_sync.sv
// Multi-stage synchronizer with edge detection for a group of async lines.
module i2cb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '1;
      hist <= '1;
    end else begin
      chain[0] <= raw;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      hist <= chain[STAGES-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_line
      assign lvl[g]  = chain[STAGES-1][g];
      assign rise[g] = chain[STAGES-1][g] & ~hist[g];
      assign fall[g] = ~chain[STAGES-1][g] & hist[g];
    end
  endgenerate
endmodule

// File: rtl/i2cb_link.sv
// Bit engine: start/stop, byte shifting, acknowledge and transmit drive.
module i2cb_link
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_l,
  input  logic              scl_r,
  input  logic              scl_f,
  input  logic              sda_l,
  input  logic              sda_r,
  input  logic              sda_f,
  input  logic              ack_in,
  input  logic              go_tx,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              tx_load,
  output logic              start_det,
  output logic              stop_det
);
  localparam int CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  link_st_t          st;
  logic [CW-1:0]     bitc;
  logic              in_ack;
  logic              acked;
  logic              mnack;
  logic [BYTE_W-1:0] sr;
  logic [BYTE_W-1:0] txsr;
  logic              oe_q;

  assign start_det = sda_f & scl_l & ~scl_r;
  assign stop_det  = sda_r & scl_l & ~scl_r;

  assign byte_done = (st == L_RX) & scl_f & ~in_ack & (bitc == FULL);
  assign tx_load   = scl_f & in_ack &
                     (((st == L_RX) & acked & go_tx) | ((st == L_TX) & ~mnack));
  assign rx_byte   = sr;
  assign sda_oe    = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= L_IDLE;
      bitc   <= '0;
      in_ack <= 1'b0;
      acked  <= 1'b0;
      mnack  <= 1'b0;
      sr     <= '0;
      txsr   <= '0;
      oe_q   <= 1'b0;
    end else if (stop_det) begin
      st     <= L_IDLE;
      in_ack <= 1'b0;
      oe_q   <= 1'b0;
    end else if (start_det) begin
      st     <= L_RX;
      bitc   <= '0;
      in_ack <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      case (st)
        L_RX: begin
          if (scl_r && !in_ack && bitc < FULL) begin
            sr   <= {sr[BYTE_W-2:0], sda_l};
            bitc <= bitc + 1'b1;
          end
          if (scl_f) begin
            if (in_ack) begin
              in_ack <= 1'b0;
              bitc   <= '0;
              if (!acked) begin
                st   <= L_IGN;
                oe_q <= 1'b0;
              end else if (go_tx) begin
                st    <= L_TX;
                txsr  <= tx_byte;
                mnack <= 1'b0;
                oe_q  <= ~tx_byte[BYTE_W-1];
              end else begin
                oe_q <= 1'b0;
              end
            end else if (bitc == FULL) begin
              in_ack <= 1'b1;
              acked  <= ack_in;
              oe_q   <= ack_in;
            end
          end
        end
        L_TX: begin
          if (scl_r) begin
            if (in_ack) mnack <= sda_l;
            else        bitc  <= bitc + 1'b1;
          end
          if (scl_f) begin
            if (in_ack) begin
              in_ack <= 1'b0;
              bitc   <= '0;
              if (mnack) begin
                st   <= L_IGN;
                oe_q <= 1'b0;
              end else begin
                txsr <= tx_byte;
                oe_q <= ~tx_byte[BYTE_W-1];
              end
            end else if (bitc == FULL) begin
              in_ack <= 1'b1;
              oe_q   <= 1'b0;
            end else if (bitc != '0) begin
              txsr <= {txsr[BYTE_W-2:0], 1'b0};
              oe_q <= ~txsr[BYTE_W-2];
            end
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/i2cb_frame.sv
// Frame decoder: address match, mode handling, channel sequencing, read index.
module i2cb_frame
  import i2cb_pkg::*;
#(
  parameter int          NCH      = 14,
  parameter logic [6:0]  DEV_ADDR = 7'h2C,
  localparam int         IW       = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stream_mode,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_load,
  output logic              ack_in,
  output logic              go_tx,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IW-1:0]     rd_idx
);
  localparam logic [BYTE_W-1:0] NCH_B = BYTE_W'(NCH);
  localparam logic [IW-1:0]     LAST  = IW'(NCH - 1);

  phase_t        ph;
  logic [IW-1:0] idx;
  logic [IW-1:0] ptr;
  logic [IW-1:0] rd_q;
  logic          addr_hit;
  logic          ptr_ok;

  assign addr_hit = (rx_byte[BYTE_W-1:1] == DEV_ADDR);
  assign ptr_ok   = (rx_byte < NCH_B);

  always_comb begin
    case (ph)
      P_CTRL:         ack_in = addr_hit;
      P_INDEX:        ack_in = stream_mode | ptr_ok;
      P_DATA, P_DROP: ack_in = 1'b1;
      default:        ack_in = 1'b0;
    endcase
  end

  assign go_tx   = (ph == P_READ);
  assign wr_en   = byte_done & (ph == P_DATA);
  assign wr_idx  = idx;
  assign wr_data = rx_byte;
  assign rd_idx  = rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= P_OFF;
      idx  <= '0;
      ptr  <= '0;
      rd_q <= '0;
    end else if (stop_det) begin
      ph <= P_OFF;
    end else if (start_det) begin
      ph  <= P_CTRL;
      idx <= '0;
    end else begin
      if (byte_done) begin
        case (ph)
          P_CTRL: begin
            if (!addr_hit) begin
              ph <= P_OFF;
            end else if (rx_byte[0]) begin
              ph   <= P_READ;
              rd_q <= stream_mode ? '0 : ptr;
            end else begin
              ph <= P_INDEX;
            end
          end
          P_INDEX: begin
            if (stream_mode) begin
              idx <= '0;
              ph  <= P_DATA;
            end else if (ptr_ok) begin
              idx <= rx_byte[IW-1:0];
              ptr <= rx_byte[IW-1:0];
              ph  <= P_DATA;
            end else begin
              ph <= P_OFF;
            end
          end
          P_DATA: begin
            if (stream_mode && idx != LAST) idx <= idx + 1'b1;
            else                            ph  <= P_DROP;
          end
          default: begin
          end
        endcase
      end
      if (tx_load) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cb_bank.sv
// Channel code registers with per-channel update strobes and a read mux.
module i2cb_bank
  import i2cb_pkg::*;
#(
  parameter int                NCH      = 14,
  parameter logic [BYTE_W-1:0] RST_CODE = 8'h80,
  localparam int               IW       = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic [IW-1:0]         rd_idx,
  output logic [NCH*BYTE_W-1:0] codes,
  output logic [NCH-1:0]        upd,
  output logic [BYTE_W-1:0]     rd_data
);
  logic [BYTE_W-1:0] code_arr [NCH];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      logic hit;
      assign hit = wr_en && (wr_idx == IW'(g));
      always_ff @(posedge clk) begin
        if (rst) begin
          code_arr[g] <= RST_CODE;
          upd[g]      <= 1'b0;
        end else begin
          upd[g] <= hit;
          if (hit) code_arr[g] <= wr_data;
        end
      end
      assign codes[g*BYTE_W +: BYTE_W] = code_arr[g];
    end
  endgenerate

  assign rd_data = (rd_idx < IW'(NCH)) ? code_arr[rd_idx] : '0;
endmodule

// File: rtl/i2c_chan_bank.sv
// Top: two-wire target holding a bank of channel codes.
module i2c_chan_bank
  import i2cb_pkg::*;
#(
  parameter int                NCH         = 14,
  parameter logic [6:0]        DEV_ADDR    = 7'h2C,
  parameter logic [BYTE_W-1:0] RST_CODE    = 8'h80,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic                  stream_mode,
  output logic                  sda_oe,
  output logic [NCH*BYTE_W-1:0] chan_codes,
  output logic [NCH-1:0]        chan_upd
);
  localparam int IW = $clog2(NCH);

  logic [1:0] lvl, rise, fall;
  logic scl_s, sda_s;
  logic ack_in, go_tx, wr_en, byte_done, tx_load, start_det, stop_det;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rx_byte, rd_data;

  i2cb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  ({sda_in, scl_in}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  assign scl_s = lvl[0];
  assign sda_s = lvl[1];

  i2cb_link u_link (
    .clk       (clk),
    .rst       (rst),
    .scl_l     (scl_s),
    .scl_r     (rise[0]),
    .scl_f     (fall[0]),
    .sda_l     (sda_s),
    .sda_r     (rise[1]),
    .sda_f     (fall[1]),
    .ack_in    (ack_in),
    .go_tx     (go_tx),
    .tx_byte   (rd_data),
    .sda_oe    (sda_oe),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .tx_load   (tx_load),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cb_frame #(.NCH(NCH), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .stream_mode (stream_mode),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .tx_load     (tx_load),
    .ack_in      (ack_in),
    .go_tx       (go_tx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_idx      (rd_idx)
  );

  i2cb_bank #(.NCH(NCH), .RST_CODE(RST_CODE)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .codes   (chan_codes),
    .upd     (chan_upd),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/i2cb_check.sv
// Property checker attached to the top module.
module i2cb_check #(
  parameter int NCH = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             stop_det,
  input logic [NCH-1:0]   chan_upd,
  input logic [NCH*8-1:0] chan_codes
);
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_upd_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_upd));

  assert_upd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (|chan_upd) |=> !(|chan_upd));

  assert_codes_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(|chan_upd) |-> $stable(chan_codes));
endmodule

bind i2c_chan_bank i2cb_check #(.NCH(NCH)) u_check (
  .clk        (clk),
  .rst        (rst),
  .sda_oe     (sda_oe),
  .scl_s      (scl_s),
  .stop_det   (stop_det),
  .chan_upd   (chan_upd),
  .chan_codes (chan_codes)
);

// File: tb/tb_i2c_chan_bank.sv
`timescale 1ns/1ps
module tb_i2c_chan_bank;
  localparam int NCH = 14;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic mode  = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NCH*8-1:0] chan_codes;
  logic [NCH-1:0]   chan_upd;

  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_chan_bank dut (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_m),
    .sda_in      (sda_line),
    .stream_mode (mode),
    .sda_oe      (sda_oe),
    .chan_codes  (chan_codes),
    .chan_upd    (chan_upd)
  );

  int n_chk = 0;
  int n_fail = 0;
  int r11_bad = 0;
  bit done = 0;
  logic [7:0] model [NCH];
  int exp_pulse [NCH];
  int got_pulse [NCH];
  logic [3:0] ptr_m = 4'd0;
  logic [7:0] wbuf [20];
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (!rst)
      for (int c = 0; c < NCH; c++) if (chan_upd[c]) got_pulse[c] <= got_pulse[c] + 1;
  end

  always @(negedge clk) begin
    if (!rst && sda_oe != oe_prev && scl_m) r11_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input bit b, output bit s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], s);
    bit_clk(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b, output bit ackline);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, s);
      b[i] = s;
    end
    bit_clk(!mack, s);
    ackline = s;
  endtask

  task automatic check_all(input string tag);
    tick(4);
    for (int c = 0; c < NCH; c++) begin
      chk(chan_codes[c*8 +: 8] == model[c], tag, chan_codes[c*8 +: 8], model[c]);
      chk(got_pulse[c] == exp_pulse[c], {tag, " strobe count R8"}, got_pulse[c], exp_pulse[c]);
    end
  endtask

  // Write frame: control byte then n bytes from wbuf (wbuf[0] = index/pointer).
  task automatic write_frame(input logic [6:0] a, input int n, input bit stop_it);
    bit ack, e, ign;
    string tag;
    int ch;
    do_start();
    send_byte({a, 1'b0}, ack);
    e = (a == DEV);
    chk(ack == e, "R3 control ack", ack, e);
    ign = !e;
    for (int i = 0; i < n; i++) begin
      if (ign) begin
        e = 0;
        tag = (a == DEV) ? "R7 ignored byte" : "R3 ignored byte";
      end else if (i == 0) begin
        if (mode) begin
          e = 1; tag = "R4 index byte";
        end else if (wbuf[0] < 8'd14) begin
          e = 1; tag = "R6 pointer"; ptr_m = wbuf[0][3:0];
        end else begin
          e = 0; tag = "R7 bad pointer"; ign = 1;
        end
      end else begin
        e = 1;
        if (mode) begin
          ch = i - 1;
          if (ch < NCH) begin
            model[ch] = wbuf[i]; exp_pulse[ch]++; tag = "R4 data";
          end else tag = "R5 overflow byte";
        end else if (i == 1) begin
          model[ptr_m] = wbuf[i]; exp_pulse[ptr_m]++; tag = "R6 data";
        end else tag = "R6 extra byte";
      end
      send_byte(wbuf[i], ack);
      chk(ack == e, tag, ack, e);
    end
    if (stop_it) begin
      do_stop();
      chk(sda_line == 1'b1, "R2 released after stop", sda_line, 1);
    end
  endtask

  task automatic read_frame(input int n);
    bit ack, s;
    logic [7:0] b;
    int idx;
    do_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack == 1'b1, "R9 read control ack", ack, 1);
    idx = mode ? 0 : int'(ptr_m);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b, s);
      chk(b == model[idx], "R9 read data", b, model[idx]);
      if (k == n - 1) chk(s == 1'b1, "R10 released on nack", s, 1);
      idx = (idx + 1) % NCH;
    end
    for (int k = 0; k < 9; k++) begin
      bit_clk(1'b1, s);
      chk(s == 1'b1, "R10 silent after nack", s, 1);
    end
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack;
    int n;
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < NCH; c++) begin
      model[c] = 8'h80; exp_pulse[c] = 0; got_pulse[c] = 0;
    end
    tick(10);
    rst = 1'b0;
    tick(4);

    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(chan_upd == '0, "R1 no strobes", chan_upd, 0);
    check_all("R1 reset code");

    // R4/R5 full streaming frame with overflow
    mode = 1'b1;
    wbuf[0] = 8'h00;
    for (int i = 1; i < 17; i++) wbuf[i] = 8'($urandom);
    write_frame(DEV, 17, 1);
    check_all("R4 stream frame");

    // R5 repeated start restarts at channel 1
    for (int i = 0; i < 4; i++) wbuf[i] = 8'($urandom);
    write_frame(DEV, 4, 0);
    for (int i = 0; i < 3; i++) wbuf[i] = 8'($urandom);
    write_frame(DEV, 3, 1);
    check_all("R5 repeated start");

    // R3 foreign address ignored
    for (int i = 0; i < 3; i++) wbuf[i] = 8'($urandom);
    write_frame(DEV ^ 7'h01, 3, 1);
    check_all("R3 foreign address");

    // R9 streaming read with wrap, R10 nack
    read_frame(16);

    // R6 register mode single channel
    mode = 1'b0;
    wbuf[0] = 8'd5; wbuf[1] = 8'hA5; wbuf[2] = 8'h3C;
    write_frame(DEV, 3, 1);
    check_all("R6 register write");
    wbuf[0] = 8'd13; wbuf[1] = 8'h01;
    write_frame(DEV, 2, 1);
    check_all("R6 last channel");

    // R7 pointers out of range
    wbuf[0] = 8'd14; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    write_frame(DEV, 3, 1);
    wbuf[0] = 8'hC8; wbuf[1] = 8'h77;
    write_frame(DEV, 2, 1);
    check_all("R7 bad pointer");

    // R9 register-mode read from pointer 12 with wrap
    wbuf[0] = 8'd12;
    write_frame(DEV, 1, 0);
    read_frame(4);

    // R2 stop mid-frame, then clocking with no start
    mode = 1'b1;
    wbuf[0] = 8'h00;
    write_frame(DEV, 1, 1);
    send_byte({DEV, 1'b0}, ack);
    chk(ack == 1'b0, "R2 no ack outside frame", ack, 0);
    send_byte(8'hFF, ack);
    chk(ack == 1'b0, "R2 no ack outside frame", ack, 0);
    check_all("R2 outside frame");

    // Random frames mixing both modes
    for (int f = 0; f < 18; f++) begin
      logic [6:0] a;
      mode = 1'($urandom);
      a = ($urandom % 6 == 0) ? 7'($urandom) : DEV;
      n = 1 + int'($urandom % 5);
      wbuf[0] = mode ? 8'($urandom) : 8'($urandom % 16);
      for (int i = 1; i < n; i++) wbuf[i] = 8'($urandom);
      write_frame(a, n, 1);
      check_all(mode ? "R4 random stream" : "R6 random register");
      if ($urandom % 3 == 0) read_frame(1 + int'($urandom % 4));
    end

    chk(r11_bad == 0, "R11 drive change with SCL high", r11_bad, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule